// File: doc/BRIEF.md
# Serially Programmable Peripheral Address Decoder

This block produces the active-low chip selects for a small 32-bit processor system. The system has six slots: boot ROM, RAM, a configuration-controller mailbox, two serial ports and a parallel port. No jumpers set the slot base addresses. Each slot owns an 8-bit identity register that a configuration controller fills serially, one bit per shift cycle. A slot is selected when an 8-bit field of the upper address lines equals its identity, the slot is enabled, and the address strobe is asserted.

After reset every identity is zero. Only the boot ROM is enabled, so the processor fetches from address zero. The ROM has its own active-low enable. The five other slots share a group enable, which the controller sets after it has loaded their identities. The controller loads its own slot first, usually with identity 0x01, which gives base 0x80000 just above a 512 KB ROM. Later it can turn the ROM off and move RAM to identity 0x00, so the whole map can change at run time.

If several enabled slots claim one address, a fixed priority lets only one select go low. The order is ROM, then RAM, then the I/O slots in index order. An identity register cannot change while its slot is enabled.

Top module: `addr_map_decoder`

## Requirements
- R1: While rst is high, and on the first cycle after it falls, every cs_n bit is 1. Reset clears all six identity registers to 0x00.
- R2: The slot index assignment is 0=ROM, 1=RAM, 2=mailbox, 3=serial0, 4=serial1 and 5=parallel. While grp_en is 0, cs_n[5:1] stay 1 whatever the address.
- R3: On a clock edge with cfg_shift=1 and cfg_load[i]=1 for a disabled slot i, cfg_sdata shifts into bit 0 of identity i and the older bits move up one place. Eight shifts therefore load a byte sent MSB first.
- R4: A shift has no effect on a slot whose cfg_load bit is 0. It also has no effect on an enabled slot. The ROM is enabled when rom_en_n=0, and the other slots are enabled when grp_en=1.
- R5: cs_n[i] is 0 in cycle t+1 exactly when, at edge t, as_n=0, slot i is enabled, its identity equals the compare field, and no higher-priority slot also qualifies.
- R6: When two or more slots qualify, only the lowest index is selected. At most one cs_n bit is 0 at any time.
- R7: After a clock edge with as_n=1, all cs_n bits are 1.
- R8: With rom_en_n=1, cs_n[0] stays 1. A RAM identity of 0x00 then selects RAM at address zero.
- R9: The compare field is addr[26:19]. No other address bit affects any select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low |
| addr | input | 32 | Processor address bus |
| rom_en_n | input | 1 | Dedicated ROM slot enable, active low |
| grp_en | input | 1 | Group enable for slots 1 to 5, active high |
| cfg_shift | input | 1 | Serial shift qualifier, one bit per clock |
| cfg_sdata | input | 1 | Serial identity data, MSB first |
| cfg_load | input | 6 | Per-slot load strobe selecting the target register |
| cs_n | output | 6 | Registered chip selects, active low, one per slot |

## Verification
A wrong bit in an identity register does not appear at the ports until the address field reaches the affected value. For this reason every configuration phase is followed by a sweep of all 256 field values. Each sweep shows the whole map one cycle after each address is applied.

A shift that was wrongly accepted, or a shift into the wrong slot, appears as a moved or missing select in the next sweep. A priority or gating fault appears as two low selects, or as a select with no strobe, one cycle after the offending input.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int NUM_SLOTS = 6;
    localparam int ID_W      = 8;
    localparam int ADDR_W    = 32;
    localparam int FIELD_LSB = 19;

    typedef enum int unsigned {
        SLOT_ROM  = 0,
        SLOT_RAM  = 1,
        SLOT_MBOX = 2,
        SLOT_SER0 = 3,
        SLOT_SER1 = 4,
        SLOT_PAR  = 5
    } slot_e;

    typedef logic [ID_W-1:0] ident_t;

    // Shift one serial bit into the low end of an identity value.
    function automatic ident_t shift_in(input ident_t cur, input logic bit_in);
        return {cur[ID_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/ident_shreg.sv
module ident_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdata,
    output logic [W-1:0] ident
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ident <= '0;
        end else if (shift_en) begin
            ident <= {ident[W-2:0], sdata};
        end
    end
endmodule

// File: rtl/slot_cmp.sv
module slot_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] ident,
    input  logic [W-1:0] field,
    input  logic         enable,
    output logic         hit
);
    always_comb begin
        hit = enable && (ident == field);
    end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import addr_dec_pkg::*;
#(
    parameter int N_SLOT = NUM_SLOTS,
    parameter int IDW    = ID_W,
    parameter int AW     = ADDR_W,
    parameter int FLSB   = FIELD_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic [AW-1:0]     addr,
    input  logic              rom_en_n,
    input  logic              grp_en,
    input  logic              cfg_shift,
    input  logic              cfg_sdata,
    input  logic [N_SLOT-1:0] cfg_load,
    output logic [N_SLOT-1:0] cs_n
);
    localparam int FMSB = FLSB + IDW - 1;

    logic [IDW-1:0]        field;
    logic [N_SLOT-1:0]     slot_en;
    logic [N_SLOT-1:0]     hit;
    logic [N_SLOT-1:0]     grant;
    logic [N_SLOT*IDW-1:0] id_flat;
    logic                  unused_addr_bits;

    assign field = addr[FMSB:FLSB];
    assign unused_addr_bits = ^{addr[AW-1:FMSB+1], addr[FLSB-1:0]};

    genvar gi;
    generate
        for (gi = 0; gi < N_SLOT; gi++) begin : g_slot
            logic [IDW-1:0] ident;
            logic           shift_ok;

            if (gi == int'(SLOT_ROM)) begin : g_rom_en
                assign slot_en[gi] = ~rom_en_n;
            end else begin : g_grp_en
                assign slot_en[gi] = grp_en;
            end

            // A slot accepts serial data only while it is disabled.
            assign shift_ok = cfg_shift && cfg_load[gi] && !slot_en[gi];

            ident_shreg #(.W(IDW)) u_reg (
                .clk      (clk),
                .rst      (rst),
                .shift_en (shift_ok),
                .sdata    (cfg_sdata),
                .ident    (ident)
            );

            slot_cmp #(.W(IDW)) u_cmp (
                .ident  (ident),
                .field  (field),
                .enable (slot_en[gi] && !as_n),
                .hit    (hit[gi])
            );

            assign id_flat[gi*IDW +: IDW] = ident;
        end
    endgenerate

    prio_pick #(.N(N_SLOT)) u_pick (
        .req   (hit),
        .grant (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= '1;
        end else begin
            cs_n <= ~grant;
        end
    end
endmodule

// File: rtl/addr_map_decoder_chk.sv
module addr_map_decoder_chk #(
    parameter int N_SLOT = 6,
    parameter int IDW    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              as_n,
    input logic              rom_en_n,
    input logic              grp_en,
    input logic [N_SLOT-1:0] cs_n,
    input logic [N_SLOT-1:0] slot_en,
    input logic [N_SLOT*IDW-1:0] id_flat
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (&cs_n)); // R1

    AST_GROUP_GATE: assert property (@(posedge clk) disable iff (rst)
        !grp_en |=> (&cs_n[N_SLOT-1:1])); // R2

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R6

    AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (&cs_n)); // R7

    AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |-> $past(!as_n)); // R5

    AST_ROM_GATE: assert property (@(posedge clk) disable iff (rst)
        rom_en_n |=> cs_n[0]); // R8

    genvar gi;
    generate
        for (gi = 0; gi < N_SLOT; gi++) begin : g_hold
            AST_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
                slot_en[gi] |=> $stable(id_flat[gi*IDW +: IDW])); // R4
        end
    endgenerate
endmodule

bind addr_map_decoder addr_map_decoder_chk #(.N_SLOT(N_SLOT), .IDW(IDW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .as_n     (as_n),
    .rom_en_n (rom_en_n),
    .grp_en   (grp_en),
    .cs_n     (cs_n),
    .slot_en  (slot_en),
    .id_flat  (id_flat)
);

// File: tb/sim_addr_map_decoder.sv
`timescale 1ns/1ps
module sim_addr_map_decoder;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          as_n;
    logic [31:0]   addr;
    logic          rom_en_n;
    logic          grp_en;
    logic          cfg_shift;
    logic          cfg_sdata;
    logic [NS-1:0] cfg_load;
    logic [NS-1:0] cs_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [7:0] exp_id [NS];

    always #10 clk = ~clk;

    addr_map_decoder u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .addr(addr),
        .rom_en_n(rom_en_n), .grp_en(grp_en), .cfg_shift(cfg_shift),
        .cfg_sdata(cfg_sdata), .cfg_load(cfg_load), .cs_n(cs_n)
    );

    task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cs_n actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic slot_on(input int i);
        return (i == 0) ? !rom_en_n : grp_en;
    endfunction

    function automatic logic [NS-1:0] exp_cs(input logic [31:0] a, input logic strb_n);
        logic [NS-1:0] r;
        logic [7:0] f;
        r = '1;
        f = a[26:19];
        if (!strb_n) begin
            for (int i = NS - 1; i >= 0; i--) begin
                if (slot_on(i) && exp_id[i] == f) r = ~(NS'(1) << i);
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_addr(input int f);
        logic [31:0] a;
        a = (32'(f) * 32'h9E37) ^ 32'h5A5A_5A5A;
        a[26:19] = 8'(f);
        return a;
    endfunction

    task automatic load_slot(input int idx, input logic [7:0] val);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_load  = NS'(1) << idx;
            cfg_sdata = val[b];
            if (!slot_on(idx)) exp_id[idx] = {exp_id[idx][6:0], val[b]};
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_load  = '0;
        cfg_sdata = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int f = 0; f < 256; f++) begin
            @(negedge clk);
            addr = mk_addr(f);
            as_n = 1'b0;
            @(posedge clk);
            #1 check(tag, cs_n, exp_cs(addr, 1'b0));
        end
        @(negedge clk);
        as_n = 1'b1;
        @(posedge clk);
        #1 check("R7 release after sweep", cs_n, '1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) exp_id[i] = 8'h00;
        rst = 1'b1; as_n = 1'b0; addr = '0; rom_en_n = 1'b0; grp_en = 1'b0;
        cfg_shift = 1'b0; cfg_sdata = 1'b0; cfg_load = '0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset holds selects high", cs_n, '1);
        @(negedge clk);
        rst = 1'b0; as_n = 1'b1;
        @(posedge clk);
        #1 check("R1 idle after reset", cs_n, '1);

        // Reset map: only ROM at field 0; group disabled.
        sweep("R2 R5 R9 boot map");

        // Shifts into the enabled ROM are ignored.
        load_slot(0, 8'hFF);
        sweep("R4 enabled ROM not reloaded");

        // Load controller first, then the others (RAM at 0, two serials sharing 0x03).
        load_slot(2, 8'h01);
        load_slot(1, 8'h00);
        load_slot(3, 8'h03);
        load_slot(4, 8'h03);
        load_slot(5, 8'hA5);
        // Shift with no strobe: nothing moves.
        @(negedge clk);
        cfg_shift = 1'b1; cfg_sdata = 1'b1;
        repeat (4) @(negedge clk);
        cfg_shift = 1'b0; cfg_sdata = 1'b0;
        sweep("R2 group still off after loading");

        @(negedge clk);
        grp_en = 1'b1;
        sweep("R3 R6 full map enabled");

        // Reload of an enabled slot is ignored.
        load_slot(2, 8'h77);
        sweep("R4 enabled mailbox not reloaded");

        @(negedge clk);
        rom_en_n = 1'b1;
        sweep("R8 ROM off, RAM at zero");

        // ROM reload while disabled, then re-enable it.
        load_slot(0, 8'h3C);
        @(negedge clk);
        rom_en_n = 1'b0;
        sweep("R3 ROM relocated");

        // Strobe pulse on a matching address.
        @(negedge clk);
        addr = mk_addr(8'h01); as_n = 1'b0;
        @(posedge clk);
        #1 check("R5 mailbox select", cs_n, 6'b111011);
        @(negedge clk);
        as_n = 1'b1;
        @(posedge clk);
        #1 check("R7 strobe drop releases", cs_n, '1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule